// File: doc/BRIEF.md
# Emulation Step Sequencer for a Partitioned Cycle-Accurate Model

This controller advances one slice of a cycle-accurate hardware model that has been split across several chips. Each emulated target cycle passes through three phases. In the evaluate phase the model logic receives a single clock-enable pulse. In the exchange phase the model is frozen while its boundary outputs are sent to the neighbouring partition over a narrow parallel link, one slice per host cycle, and the neighbour's boundary values are received. In the host phase the controller waits for the host, which supplies the core requests for the next cycle and collects the completion flags of the one just evaluated.

The boundary vector is too wide for the pins, so it is shipped in `SLICES = ceil(BND_W / LINK_W)` slices inside a fixed window of `SYNC_CYC` host cycles. The received boundary goes into a shadow register that feeds the local boundary inputs. That register is replaced only when a complete frame has arrived, so the neighbour's new values can never reach the local logic in the same emulated cycle. A window that ends without a complete frame stops the emulation for good, until reset.

Top module: `emu_step_seq`

## Requirements
- R1: `clk_en_o` is high for exactly one host cycle per emulated cycle. That cycle follows the clock edge at which `host_rdy_i` is sampled high in the host phase, and `clk_en_o` is never high in two consecutive cycles.
- R2: The cycle after the enable pulse starts the exchange phase. `sync_phase_o` then stays high for exactly `SYNC_CYC` cycles, and `clk_en_o` is low throughout.
- R3: `bnd_out_i` is captured at the edge that ends the enable cycle and zero-padded to `SLICES*LINK_W` bits. On exchange cycle j (counting from 0, with j < `SLICES`), `tx_vld_o` is high and `tx_data_o` carries bits [j*LINK_W +: LINK_W]. `tx_sof_o` is high only on j = 0. On all later exchange cycles, and outside the exchange phase, `tx_vld_o` and `tx_sof_o` are low.
- R4: Incoming slices are counted only during the exchange phase, and only when `rx_vld_i` is high. A slice with `rx_sof_i` high starts a frame as slice 0, and this also restarts a frame that is partly received. Slices without `rx_sof_i` fill positions 1, 2 and so on in order. A slice without `rx_sof_i` that arrives before any start is ignored.
- R5: `bnd_in_o` takes the low `BND_W` bits of the assembled frame (slice j at bits j*LINK_W) at the edge that accepts the final slice, including a final slice on the last exchange cycle. It changes at no other time: slices that arrive after a frame is complete in the same window, and any `rx_*` activity outside the exchange phase, leave it unchanged.
- R6: If the exchange window closes without a complete frame, `sync_err_o` goes high and stays high. Once it is set, `clk_en_o`, `sync_phase_o` and `hif_phase_o` stay low regardless of `host_rdy_i`, until reset.
- R7: `hif_phase_o` is high in the host phase. `ack_o` holds `done_i` as sampled at the edge that ends the enable cycle. `ack_vld_o` is high for exactly the first host-phase cycle after a successful exchange. `stim_o` takes `core_req_i` at the edge where `host_rdy_i` releases the next enable cycle.
- R8: After synchronous active-high reset, the block is in the host phase: `hif_phase_o` is 1, `ack_vld_o` is 0, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| host_rdy_i | input | 1 | Host ready to release the next emulated cycle |
| core_req_i | input | N_CORE | Core request stimulus from the host |
| done_i | input | N_CORE | Completion flags from the model logic |
| bnd_out_i | input | BND_W | Local boundary outputs of the model |
| bnd_in_o | output | BND_W | Shadow copy of the neighbour's boundary |
| clk_en_o | output | 1 | Clock enable for the model logic |
| sync_phase_o | output | 1 | Exchange phase active |
| hif_phase_o | output | 1 | Host phase active |
| sync_err_o | output | 1 | Sticky incomplete-frame error |
| stim_o | output | N_CORE | Requests applied to the current emulated cycle |
| ack_o | output | N_CORE | Completion flags of the last evaluated cycle |
| ack_vld_o | output | 1 | One-cycle strobe marking a fresh `ack_o` |
| tx_data_o | output | LINK_W | Outgoing link slice |
| tx_vld_o | output | 1 | Outgoing slice valid |
| tx_sof_o | output | 1 | Outgoing slice is slice 0 |
| rx_data_i | input | LINK_W | Incoming link slice |
| rx_vld_i | input | 1 | Incoming slice valid |
| rx_sof_i | input | 1 | Incoming slice is slice 0 |

## Verification
The bench builds the block with `LINK_W = 8`, `BND_W = 20`, `SYNC_CYC = 6` and `N_CORE = 4`. With these values a frame has three slices and four padding bits, and the window has three spare cycles. This room lets a frame arrive with gaps, end on the very last window cycle, be preceded by stray slices, restart partway through, or be followed by surplus slices. A short frame then drives the block into its stopped state. A final reset checks that the block recovers from it.

// File: rtl/emu_step_pkg.sv
package emu_step_pkg;

    typedef enum logic [1:0] {
        PH_HOST = 2'd0,
        PH_EVAL = 2'd1,
        PH_XCHG = 2'd2,
        PH_STOP = 2'd3
    } phase_e;

    function automatic int slices_for(input int bits, input int lane);
        return (bits + lane - 1) / lane;
    endfunction

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/emu_phase_ctrl.sv
module emu_phase_ctrl
    import emu_step_pkg::*;
#(
    parameter int SYNC_CYC = 18,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rdy_i,
    input  logic          frame_ok_i,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          eval_end_o,
    output logic          xchg_last_o
);
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign eval_end_o  = (phase_q == PH_EVAL);
    assign xchg_last_o = (phase_q == PH_XCHG) && (cnt_q == CW'(SYNC_CYC - 1));
    assign phase_o     = phase_q;
    assign cnt_o       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOST;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_HOST: if (host_rdy_i) phase_q <= PH_EVAL;
                PH_EVAL: begin
                    phase_q <= PH_XCHG;
                    cnt_q   <= '0;
                end
                PH_XCHG: begin
                    if (xchg_last_o) phase_q <= frame_ok_i ? PH_HOST : PH_STOP;
                    else             cnt_q   <= cnt_q + CW'(1);
                end
                default: phase_q <= PH_STOP;
            endcase
        end
    end
endmodule

// File: rtl/emu_link_tx.sv
module emu_link_tx #(
    parameter int BND_W  = 624,
    parameter int LINK_W = 98,
    parameter int SLICES = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [BND_W-1:0]  bnd_i,
    output logic [LINK_W-1:0] data_o
);
    localparam int PAD_W = SLICES * LINK_W;

    logic [PAD_W-1:0] sreg_q;

    assign data_o = sreg_q[LINK_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)          sreg_q <= '0;
        else if (load_i)  sreg_q <= PAD_W'(bnd_i);
        else if (shift_i) sreg_q <= sreg_q >> LINK_W;
    end
endmodule

// File: rtl/emu_link_rx.sv
module emu_link_rx
    import emu_step_pkg::*;
#(
    parameter int BND_W  = 624,
    parameter int LINK_W = 98,
    parameter int SLICES = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              open_i,
    input  logic              vld_i,
    input  logic              sof_i,
    input  logic [LINK_W-1:0] data_i,
    output logic [BND_W-1:0]  shadow_o,
    output logic              frame_ok_o
);
    localparam int PAD_W = SLICES * LINK_W;
    localparam int RW    = cnt_bits(SLICES + 1);

    logic [PAD_W-1:0] asm_q, asm_nxt;
    logic [RW-1:0]    rcnt_q, rcnt_nxt;
    logic             done_q, accept, commit;

    generate
        if (SLICES == 1) begin : g_single
            assign asm_nxt = data_i;
        end else begin : g_multi
            assign asm_nxt = {data_i, asm_q[PAD_W-1:LINK_W]};
        end
    endgenerate

    assign accept     = open_i && vld_i && !done_q && (sof_i || (rcnt_q != '0));
    assign rcnt_nxt   = sof_i ? RW'(1) : rcnt_q + RW'(1);
    assign commit     = accept && (rcnt_nxt == RW'(SLICES));
    assign frame_ok_o = done_q || commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q    <= '0;
            rcnt_q   <= '0;
            done_q   <= 1'b0;
            shadow_o <= '0;
        end else if (clear_i) begin
            rcnt_q <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            asm_q  <= asm_nxt;
            rcnt_q <= rcnt_nxt;
            if (commit) begin
                done_q   <= 1'b1;
                shadow_o <= asm_nxt[BND_W-1:0];
            end
        end
    end
endmodule

// File: rtl/emu_step_seq.sv
module emu_step_seq
    import emu_step_pkg::*;
#(
    parameter int N_CORE   = 64,
    parameter int BND_W    = 624,
    parameter int LINK_W   = 98,
    parameter int SYNC_CYC = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rdy_i,
    input  logic [N_CORE-1:0] core_req_i,
    input  logic [N_CORE-1:0] done_i,
    input  logic [BND_W-1:0]  bnd_out_i,
    output logic [BND_W-1:0]  bnd_in_o,
    output logic              clk_en_o,
    output logic              sync_phase_o,
    output logic              hif_phase_o,
    output logic              sync_err_o,
    output logic [N_CORE-1:0] stim_o,
    output logic [N_CORE-1:0] ack_o,
    output logic              ack_vld_o,
    output logic [LINK_W-1:0] tx_data_o,
    output logic              tx_vld_o,
    output logic              tx_sof_o,
    input  logic [LINK_W-1:0] rx_data_i,
    input  logic              rx_vld_i,
    input  logic              rx_sof_i
);
    localparam int SLICES = slices_for(BND_W, LINK_W);
    localparam int CW     = cnt_bits(SYNC_CYC);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          eval_end, xchg_last, frame_ok, send;

    emu_phase_ctrl #(.SYNC_CYC(SYNC_CYC), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_rdy_i (host_rdy_i),
        .frame_ok_i (frame_ok),
        .phase_o    (phase),
        .cnt_o      (cnt),
        .eval_end_o (eval_end),
        .xchg_last_o(xchg_last)
    );

    assign send = (phase == PH_XCHG) && (int'(cnt) < SLICES);

    emu_link_tx #(.BND_W(BND_W), .LINK_W(LINK_W), .SLICES(SLICES)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .load_i (eval_end),
        .shift_i(send),
        .bnd_i  (bnd_out_i),
        .data_o (tx_data_o)
    );

    emu_link_rx #(.BND_W(BND_W), .LINK_W(LINK_W), .SLICES(SLICES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (eval_end),
        .open_i    (phase == PH_XCHG),
        .vld_i     (rx_vld_i),
        .sof_i     (rx_sof_i),
        .data_i    (rx_data_i),
        .shadow_o  (bnd_in_o),
        .frame_ok_o(frame_ok)
    );

    assign clk_en_o     = (phase == PH_EVAL);
    assign sync_phase_o = (phase == PH_XCHG);
    assign hif_phase_o  = (phase == PH_HOST);
    assign sync_err_o   = (phase == PH_STOP);
    assign tx_vld_o     = send;
    assign tx_sof_o     = send && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stim_o    <= '0;
            ack_o     <= '0;
            ack_vld_o <= 1'b0;
        end else begin
            ack_vld_o <= xchg_last && frame_ok;
            if (eval_end) ack_o <= done_i;
            if ((phase == PH_HOST) && host_rdy_i) stim_o <= core_req_i;
        end
    end
endmodule

// File: rtl/emu_step_seq_chk.sv
module emu_step_seq_chk #(
    parameter int BND_W = 624
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic             sync_phase,
    input logic             sync_err,
    input logic             ack_vld,
    input logic             tx_vld,
    input logic             tx_sof,
    input logic [BND_W-1:0] bnd_in
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> !clk_en);
    a_r2_sync_follows: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> sync_phase);
    a_r2_frozen_in_sync: assert property (@(posedge clk) disable iff (rst)
        sync_phase |-> !clk_en);
    a_r3_sof_needs_vld: assert property (@(posedge clk) disable iff (rst)
        tx_sof |-> tx_vld);
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !sync_phase |=> $stable(bnd_in));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err);
    a_r6_err_frozen: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> !clk_en);
    a_r7_ack_strobe: assert property (@(posedge clk) disable iff (rst)
        ack_vld |=> !ack_vld);
endmodule

bind emu_step_seq emu_step_seq_chk #(.BND_W(BND_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en_o),
    .sync_phase(sync_phase_o),
    .sync_err  (sync_err_o),
    .ack_vld   (ack_vld_o),
    .tx_vld    (tx_vld_o),
    .tx_sof    (tx_sof_o),
    .bnd_in    (bnd_in_o)
);

// File: tb/emu_step_seq_test.sv
module emu_step_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4, BW = 20, LW = 8, SC = 6, SL = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic host_rdy = 1'b0;
    logic [NC-1:0] core_req = '0, done = '0;
    logic [BW-1:0] bnd_out = '0;
    logic [LW-1:0] rx_data = '0;
    logic rx_vld = 1'b0, rx_sof = 1'b0;
    logic [BW-1:0] bnd_in;
    logic [NC-1:0] stim, ack;
    logic [LW-1:0] tx_data;
    logic clk_en, sync_phase_o, hif_phase, sync_err, ack_vld, tx_vld, tx_sof;

    int errors = 0, checks = 0;

    emu_step_seq #(.N_CORE(NC), .BND_W(BW), .LINK_W(LW), .SYNC_CYC(SC)) uut (
        .clk(clk), .rst(rst), .host_rdy_i(host_rdy), .core_req_i(core_req),
        .done_i(done), .bnd_out_i(bnd_out), .bnd_in_o(bnd_in), .clk_en_o(clk_en),
        .sync_phase_o(sync_phase_o), .hif_phase_o(hif_phase), .sync_err_o(sync_err),
        .stim_o(stim), .ack_o(ack), .ack_vld_o(ack_vld), .tx_data_o(tx_data),
        .tx_vld_o(tx_vld), .tx_sof_o(tx_sof), .rx_data_i(rx_data),
        .rx_vld_i(rx_vld), .rx_sof_i(rx_sof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 host, 1 evaluate, 2 exchange, 3 stopped
    int m_ph = 0, m_k = 0, m_rxn = 0;
    logic m_rxdone = 0, m_ackv = 0;
    logic [23:0] m_tx = '0, m_acc = '0;
    logic [BW-1:0] m_sh = '0;
    logic [NC-1:0] m_stim = '0, m_ack = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_k = 0; m_rxn = 0; m_rxdone = 0; m_ackv = 0;
            m_tx = '0; m_acc = '0; m_sh = '0; m_stim = '0; m_ack = '0;
        end else begin
            m_ackv = 0;
            case (m_ph)
                0: if (host_rdy) begin m_stim = core_req; m_ph = 1; end
                1: begin
                    m_tx = {4'b0, bnd_out}; m_ack = done;
                    m_ph = 2; m_k = 0; m_rxn = 0; m_rxdone = 0;
                end
                2: begin
                    if (rx_vld && !m_rxdone) begin
                        if (rx_sof) begin m_acc[7:0] = rx_data; m_rxn = 1; end
                        else if (m_rxn > 0) begin m_acc[m_rxn*8 +: 8] = rx_data; m_rxn++; end
                        if (m_rxn == SL) begin m_rxdone = 1; m_sh = m_acc[BW-1:0]; end
                    end
                    if (m_k == SC - 1) begin
                        m_ph = m_rxdone ? 0 : 3;
                        m_ackv = m_rxdone;
                    end else m_k++;
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R1 clk_en", clk_en, m_ph == 1);
            check("R2 sync_phase", sync_phase_o, m_ph == 2);
            check("R3 tx_vld", tx_vld, (m_ph == 2) && (m_k < SL));
            check("R3 tx_sof", tx_sof, (m_ph == 2) && (m_k == 0));
            if (m_ph == 2 && m_k < SL) check("R3 tx_data", tx_data, m_tx[m_k*8 +: 8]);
            check("R4/R5 bnd_in", bnd_in, m_sh);
            check("R6 sync_err", sync_err, m_ph == 3);
            check("R7 hif_phase", hif_phase, m_ph == 0);
            check("R7 ack_vld", ack_vld, m_ackv);
            check("R7 ack", ack, m_ack);
            check("R7 stim", stim, m_stim);
        end
    end

    // Neighbour side: drive one exchange window in a given pattern
    task automatic window(input int mode, input logic [23:0] fr, input logic [23:0] jk);
        while (!sync_phase_o) @(negedge clk);
        host_rdy = 0;
        for (int k = 0; k < SC; k++) begin
            rx_vld = 0; rx_sof = 0; rx_data = '0;
            case (mode)
                0: if (k < 3) begin rx_vld = 1; rx_sof = (k == 0); rx_data = fr[k*8 +: 8]; end
                1: begin // gaps, last slice on final cycle
                    if (k == 2) begin rx_vld = 1; rx_sof = 1; rx_data = fr[7:0]; end
                    if (k == 4) begin rx_vld = 1; rx_data = fr[15:8]; end
                    if (k == 5) begin rx_vld = 1; rx_data = fr[23:16]; end
                end
                2: begin // stray slices before the start
                    if (k < 2) begin rx_vld = 1; rx_data = jk[k*8 +: 8]; end
                    else if (k < 5) begin rx_vld = 1; rx_sof = (k == 2); rx_data = fr[(k-2)*8 +: 8]; end
                end
                3: begin // restart in the middle
                    if (k < 2) begin rx_vld = 1; rx_sof = (k == 0); rx_data = jk[k*8 +: 8]; end
                    else if (k < 5) begin rx_vld = 1; rx_sof = (k == 2); rx_data = fr[(k-2)*8 +: 8]; end
                end
                4: begin // surplus after completion
                    if (k < 3) begin rx_vld = 1; rx_sof = (k == 0); rx_data = fr[k*8 +: 8]; end
                    else begin rx_vld = 1; rx_sof = (k == 3); rx_data = jk[(k-3)*8 +: 8]; end
                end
                default: if (k < 2) begin rx_vld = 1; rx_sof = (k == 0); rx_data = fr[k*8 +: 8]; end
            endcase
            @(negedge clk);
        end
        rx_vld = 0; rx_sof = 0; rx_data = '0;
    endtask

    task automatic step(input int mode, input int seed);
        logic [23:0] fr, jk;
        fr = 24'h5A3C00 ^ (24'h010203 * seed[23:0]);
        jk = ~fr;
        bnd_out = BW'(24'h9E3779 ^ (24'h111111 * seed[23:0]));
        done = NC'(seed * 5 + 3);
        core_req = NC'(seed * 7 + 1);
        // host holds off with stray link activity outside the window
        for (int i = 0; i < 3; i++) begin
            rx_vld = 1; rx_sof = 1; rx_data = jk[7:0];
            @(negedge clk);
        end
        rx_vld = 0; rx_sof = 0;
        host_rdy = 1;
        window(mode, fr, jk);
        if (mode < 5) check("R5 frame landed", bnd_in, fr[BW-1:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R8 reset hif", hif_phase, 1);
        check("R8 reset clk_en", clk_en, 0);
        check("R8 reset bnd_in", bnd_in, 0);
        check("R8 reset err", sync_err, 0);
        for (int s = 0; s < 5; s++) step(s, s + 1);
        step(5, 9);
        host_rdy = 1;
        repeat (8) @(negedge clk);
        check("R6 stays stopped", sync_err, 1);
        check("R6 no enable", clk_en, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        host_rdy = 0;
        check("R8 recover", hif_phase, 1);
        step(0, 12);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule